// File: doc/BRIEF.md
# Dual-Channel Edge-Select Input Capture

This block timestamps edges on two external signals against a free-running up counter. Each of the two capture channels has its own enable and its own edge selection: rising, falling or both. When a selected edge arrives, the channel copies the current counter value into its capture register. The counter wraps from all ones to zero, and each wrap sets a sticky overflow flag.

Channel A can optionally return the counter to zero on each of its events. The capture register still receives the count from before that reset, so consecutive captures give a period or a pulse width directly. A tie option feeds channel A's pin into channel B's edge detector. One pin can then serve both channels, with opposite edge selections, to measure duty cycle.

Each channel event and each wrap sets a sticky flag. The interrupt output is the OR of the flags whose enable bits are set. Software clears flags with a one-cycle clear pulse.

Top module: `edge_capture_pair`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared at that edge: `count_o`, both capture registers, `flags_o` and the synchronizers all become 0, and `irq_o` is 0.
- R2: Without a channel A clear, `count_o` rises by one at every edge and wraps from 0xFFFF to 0x0000. That wrap sets `flags_o[2]` at the same edge.
- R3: Each pin passes through a two-flop synchronizer. Suppose a pin level is first sampled at edge k and held. An edge is then detected between edges k+1 and k+2. At edge k+2 the capture register loads the `count_o` value shown in that interval.
- R4: Edge select codes, per channel, are 2'b00 none, 2'b01 rising only, 2'b10 falling only and 2'b11 both edges. An edge whose type is not selected has no effect.
- R5: While a channel's bit of `ch_en_i` (bit 0 for A, bit 1 for B) is low, edges on that channel change neither its capture register nor its flag.
- R6: With `clear_on_a_i` high, a channel A event stores the pre-reset count in `cap_a_o`. At the same edge `count_o` becomes 0, and it counts up from there.
- R7: With `tie_b_to_a_i` high, channel B detects edges on the synchronized `pin_a_i`, and `pin_b_i` has no effect.
- R8: The bits of `flags_o` are sticky: bit 0 for a channel A event, bit 1 for a channel B event and bit 2 for a wrap. Each bit clears at an edge where the matching `flag_clr_i` bit is high. If a set and a clear arrive at the same edge, the set wins.
- R9: `irq_o` is high exactly when some `flags_o` bit and the matching `irq_en_i` bit are both high.
- R10: A channel A clear at a count of 0xFFFF takes precedence over the wrap, and `flags_o[2]` is not set by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a_i | input | 1 | Asynchronous capture input, channel A |
| pin_b_i | input | 1 | Asynchronous capture input, channel B |
| ch_en_i | input | 2 | Channel enables, bit 0 is A and bit 1 is B |
| sel_a_i | input | 2 | Edge select for channel A |
| sel_b_i | input | 2 | Edge select for channel B |
| clear_on_a_i | input | 1 | Channel A events reset the counter |
| tie_b_to_a_i | input | 1 | Channel B is fed from the channel A pin |
| irq_en_i | input | 3 | Interrupt enables per flag |
| flag_clr_i | input | 3 | Flag clear pulse per flag |
| count_o | output | 16 | Counter value |
| cap_a_o | output | 16 | Channel A capture register |
| cap_b_o | output | 16 | Channel B capture register |
| flags_o | output | 3 | Sticky flags {wrap, B, A} |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: the counter wrap and a channel event detected while the count is 0xFFFF. The bench reads `count_o` and toggles a pin when the count is 0xFFFD, so that detection lands exactly on 0xFFFF. This is done once with channel B, where the capture must hold 0xFFFF and the wrap flag must also set. It is done once with channel A clearing the counter, where the capture must hold 0xFFFF and the wrap flag must stay clear. A flag clear pulse is also timed onto the edge where a capture sets the same flag. A behavioural model predicts every output, and the outputs are compared on every cycle.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

    localparam int NUM_CH  = 2;
    localparam int FLG_A   = 0;
    localparam int FLG_B   = 1;
    localparam int FLG_OVF = 2;
    localparam int NUM_FLG = 3;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic sel_match(edge_sel_e sel, edge_t e);
        return (e.rise && sel[0]) || (e.fall && sel[1]);
    endfunction

endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din};
    end

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/ecp_counter.sv
module ecp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    output logic [W-1:0] count,
    output logic         wrap
);
    // a clear in the all-ones cycle is not a wrap
    assign wrap = (count == '1) && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else              count <= count + 1'b1;
    end
endmodule

// File: rtl/ecp_edge_chan.sv
module ecp_edge_chan
    import ecp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lvl,
    input  logic         en,
    input  logic [1:0]   sel,
    input  logic [W-1:0] count,
    output logic         hit,
    output logic [W-1:0] cap
);
    logic  prev;
    edge_t ed;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign ed.rise = lvl & ~prev;
    assign ed.fall = ~lvl & prev;
    assign hit     = en && sel_match(edge_sel_e'(sel), ed);

    always_ff @(posedge clk) begin
        if (rst)      cap <= '0;
        else if (hit) cap <= count;
    end
endmodule

// File: rtl/edge_capture_pair.sv
module edge_capture_pair
    import ecp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_a_i,
    input  logic               pin_b_i,
    input  logic [1:0]         ch_en_i,
    input  logic [1:0]         sel_a_i,
    input  logic [1:0]         sel_b_i,
    input  logic               clear_on_a_i,
    input  logic               tie_b_to_a_i,
    input  logic [NUM_FLG-1:0] irq_en_i,
    input  logic [NUM_FLG-1:0] flag_clr_i,
    output logic [CNT_W-1:0]   count_o,
    output logic [CNT_W-1:0]   cap_a_o,
    output logic [CNT_W-1:0]   cap_b_o,
    output logic [NUM_FLG-1:0] flags_o,
    output logic               irq_o
);
    logic [NUM_CH-1:0] pin_raw;
    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] ch_lvl;
    logic [NUM_CH-1:0] ch_hit;
    logic [1:0]        ch_sel [NUM_CH];
    logic [CNT_W-1:0]  ch_cap [NUM_CH];
    logic              cnt_clear;
    logic              cnt_wrap;
    logic [NUM_FLG-1:0] flag_set;
    logic [NUM_FLG-1:0] flags_q;

    assign pin_raw   = {pin_b_i, pin_a_i};
    assign ch_sel[0] = sel_a_i;
    assign ch_sel[1] = sel_b_i;

    // the tie mux sits after the synchronizers, so both channels see one chain
    assign ch_lvl[0] = pin_sync[0];
    assign ch_lvl[1] = tie_b_to_a_i ? pin_sync[0] : pin_sync[1];

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            ecp_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (pin_raw[g]),
                .dout (pin_sync[g])
            );
            ecp_edge_chan #(.W(CNT_W)) u_chan (
                .clk   (clk),
                .rst   (rst),
                .lvl   (ch_lvl[g]),
                .en    (ch_en_i[g]),
                .sel   (ch_sel[g]),
                .count (count_o),
                .hit   (ch_hit[g]),
                .cap   (ch_cap[g])
            );
        end
    endgenerate

    assign cnt_clear = ch_hit[0] && clear_on_a_i;

    ecp_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .count (count_o),
        .wrap  (cnt_wrap)
    );

    assign flag_set[FLG_A]   = ch_hit[0];
    assign flag_set[FLG_B]   = ch_hit[1];
    assign flag_set[FLG_OVF] = cnt_wrap;

    // set has priority over a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~flag_clr_i) | flag_set;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & irq_en_i);
    assign cap_a_o = ch_cap[0];
    assign cap_b_o = ch_cap[1];
endmodule

// File: rtl/ecp_checker.sv
module ecp_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] cap_a_o,
    input logic [CNT_W-1:0] cap_b_o,
    input logic [2:0]       flags_o,
    input logic             irq_o,
    input logic [1:0]       ch_en_i,
    input logic             clear_on_a_i,
    input logic [2:0]       flag_clr_i,
    input logic [2:0]       irq_en_i,
    input logic [1:0]       ch_hit
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        !(ch_hit[0] && clear_on_a_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));

    p_wrap_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (count_o == ALL_ONES && !(ch_hit[0] && clear_on_a_i)) |=> flags_o[2]);

    p_clear_keeps_old_r6: assert property (@(posedge clk) disable iff (rst)
        (ch_hit[0] && clear_on_a_i) |=> (count_o == '0 && cap_a_o == $past(count_o)));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (ch_hit[0] && clear_on_a_i) |=> flags_o[2] == $past(flags_o[2] && !flag_clr_i[2]));

    p_cap_a_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ch_en_i[0] |=> cap_a_o == $past(cap_a_o));

    p_cap_b_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ch_en_i[1] |=> cap_b_o == $past(cap_b_o));

    p_sticky_a_r8: assert property (@(posedge clk) disable iff (rst)
        (flags_o[0] && !flag_clr_i[0]) |=> flags_o[0]);

    p_hit_sets_b_r8: assert property (@(posedge clk) disable iff (rst)
        ch_hit[1] |=> flags_o[1]);

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_en_i == 3'b000) |-> !irq_o);
endmodule

bind edge_capture_pair ecp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .count_o      (count_o),
    .cap_a_o      (cap_a_o),
    .cap_b_o      (cap_b_o),
    .flags_o      (flags_o),
    .irq_o        (irq_o),
    .ch_en_i      (ch_en_i),
    .clear_on_a_i (clear_on_a_i),
    .flag_clr_i   (flag_clr_i),
    .irq_en_i     (irq_en_i),
    .ch_hit       (ch_hit)
);

// File: tb/edge_capture_pair_bench.sv
`timescale 1ns/1ps
module edge_capture_pair_bench;
    localparam int MAXC = 65535;

    logic        clk = 1'b0;
    logic        rst;
    logic        pin_a, pin_b;
    logic [1:0]  ch_en, sel_a, sel_b;
    logic        clear_on_a, tie;
    logic [2:0]  irq_en, flag_clr;
    logic [15:0] count_o, cap_a_o, cap_b_o;
    logic [2:0]  flags_o;
    logic        irq_o;

    always #2.5 clk = ~clk;

    edge_capture_pair u_edge_capture_pair (
        .clk(clk), .rst(rst), .pin_a_i(pin_a), .pin_b_i(pin_b),
        .ch_en_i(ch_en), .sel_a_i(sel_a), .sel_b_i(sel_b),
        .clear_on_a_i(clear_on_a), .tie_b_to_a_i(tie),
        .irq_en_i(irq_en), .flag_clr_i(flag_clr),
        .count_o(count_o), .cap_a_o(cap_a_o), .cap_b_o(cap_b_o),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string phase = "R1";

    // behavioural reference: pin history queues, newest sample at the front
    int m_cnt = 0;
    int m_cap_a = 0, m_cap_b = 0;
    int m_flags = 0;
    bit qa[$] = '{0, 0};
    bit qb[$] = '{0, 0};
    bit m_prev_a = 0, m_prev_b = 0;

    always @(posedge clk) begin : model
        bit lv_a, lv_b, hit_a, hit_b, clr;
        int setv;
        if (rst) begin
            m_cnt = 0; m_cap_a = 0; m_cap_b = 0; m_flags = 0;
            qa = '{0, 0}; qb = '{0, 0};
            m_prev_a = 0; m_prev_b = 0;
        end else begin
            lv_a  = qa[1];
            lv_b  = tie ? qa[1] : qb[1];
            hit_a = ch_en[0] && ((lv_a && !m_prev_a && sel_a[0]) || (!lv_a && m_prev_a && sel_a[1]));
            hit_b = ch_en[1] && ((lv_b && !m_prev_b && sel_b[0]) || (!lv_b && m_prev_b && sel_b[1]));
            clr   = hit_a && clear_on_a;
            setv  = 0;
            if (hit_a) begin m_cap_a = m_cnt; setv = setv | 1; end
            if (hit_b) begin m_cap_b = m_cnt; setv = setv | 2; end
            if (!clr && m_cnt == MAXC) setv = setv | 4;
            m_cnt    = clr ? 0 : (m_cnt + 1) % (MAXC + 1);
            m_flags  = (m_flags & ~int'(flag_clr)) | setv;
            m_prev_a = lv_a;
            m_prev_b = lv_b;
            qa.push_front(pin_a); void'(qa.pop_back());
            qb.push_front(pin_b); void'(qb.pop_back());
        end
    end

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("count", int'(count_o), m_cnt);
            chk("cap_a", int'(cap_a_o), m_cap_a);
            chk("cap_b", int'(cap_b_o), m_cap_b);
            chk("flags", int'(flags_o), m_flags);
            chk("irq",   int'(irq_o),   int'((m_flags & int'(irq_en)) != 0));
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_count(logic [15:0] target);
        while (count_o !== target) tick(1);
    endtask

    initial begin
        rst = 1; pin_a = 0; pin_b = 0; ch_en = 0; sel_a = 0; sel_b = 0;
        clear_on_a = 0; tie = 0; irq_en = 0; flag_clr = 0;
        tick(4);
        rst = 0;
        phase = "R2"; tick(20);

        phase = "R3"; ch_en = 2'b11; sel_a = 2'b01; sel_b = 2'b01; irq_en = 3'b111;
        pin_a = 1; tick(6); pin_b = 1; tick(6);

        phase = "R4"; sel_a = 2'b10; pin_a = 0; tick(6); pin_a = 1; tick(6);
        sel_a = 2'b11; pin_a = 0; tick(5); pin_a = 1; tick(5);
        sel_b = 2'b00; pin_b = 0; tick(6);
        sel_b = 2'b10; pin_b = 1; tick(4); pin_b = 0; tick(6);

        phase = "R8"; flag_clr = 3'b111; tick(1); flag_clr = 0; tick(3);
        pin_a = 0; tick(2); flag_clr = 3'b001; tick(1); flag_clr = 0; tick(4);

        phase = "R9"; irq_en = 3'b010; tick(3); irq_en = 3'b001; tick(3);
        irq_en = 3'b000; tick(3); flag_clr = 3'b111; tick(1); flag_clr = 0;
        irq_en = 3'b111; tick(3);

        phase = "R5"; ch_en = 2'b00; pin_a = 1; pin_b = 1; tick(6);
        pin_a = 0; pin_b = 0; tick(6); ch_en = 2'b11; tick(3);

        phase = "R6"; sel_a = 2'b11; clear_on_a = 1;
        pin_a = 1; tick(9); pin_a = 0; tick(17); pin_a = 1; tick(4); pin_a = 0; tick(3);
        clear_on_a = 0; tick(5);

        phase = "R7"; tie = 1; sel_a = 2'b01; sel_b = 2'b10;
        pin_a = 1; tick(7); pin_b = 1; tick(3); pin_a = 0; tick(5); pin_b = 0; tick(4);
        pin_a = 1; tick(11); pin_a = 0; tick(5); tie = 0; tick(5);

        // wrap and a channel B capture in the same cycle
        phase = "R2"; sel_b = 2'b11; flag_clr = 3'b111; tick(1); flag_clr = 0;
        wait_count(16'hFFFD); pin_b = ~pin_b; tick(8);

        // channel A clear at 0xFFFF must not set the wrap flag
        phase = "R10"; sel_a = 2'b11; clear_on_a = 1; flag_clr = 3'b111; tick(1); flag_clr = 0;
        wait_count(16'hFFFD); pin_a = ~pin_a; tick(8);
        clear_on_a = 0; tick(10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog %s: actual hung expected finished", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule